// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Divider

This block sits after an external two-modulus prescaler (moduli P and P+1). It divides the prescaler output so that a synthesiser loop can compare the result with its reference. Each divider cycle lasts M input clocks. During the first A of those clocks the modulus-control output `mc` is low, which selects the larger prescaler modulus. During the remaining M−A clocks `mc` is high. The overall division from the oscillator to the divider output is therefore M·P + A.

A single up-counter sets the position within the cycle. On the last count of each cycle the block emits a one-clock pulse on `fv_edge` for the phase comparator, and the next clock starts a new cycle at count zero. New M and A values arrive through a load strobe and wait in a holding stage. They become the working pair only at a cycle boundary, so a cycle never changes length or switch point partway through. A pair that breaks the operating rule (M at least 8 and M greater than A) is refused. The error output is raised and the divider keeps the pair it already has.

Top module: `swallow_div`

## Requirements
- R1: While rst_n is low, fv_edge and cfg_err are 0 and mc is 0, because the default swallow count is 4. The first cycle after reset uses the default pair M=16, A=4.
- R2: Consecutive fv_edge pulses are exactly M input clocks apart. Each pulse lasts one clock and marks the final count of the cycle.
- R3: Within every cycle, mc is 0 on the first A counts and 1 on the remaining M−A counts. It never returns to 0 before the cycle ends.
- R4: When A=0, mc is 1 for the whole cycle, from its first count onward.
- R5: A legal pair captured by load in mid-cycle is not applied to the cycle in progress. It governs every cycle that starts at the next boundary and after it.
- R6: A load captured on the same clock edge that ends a cycle does not change the cycle that begins at that edge. It takes effect one cycle later.
- R7: A load with M<8, or with M≤A, sets cfg_err on the clock after the capture edge. The pair is discarded and the divider keeps running with the pair it was already using.
- R8: A legal load clears cfg_err on the clock after the capture edge.
- R9: The extreme legal pairs work: M=8 with A=7 (a single high count), M=9 with A=8, and M=1023 with A=127.
- R10: When several legal loads are captured within one cycle, only the last one takes effect at the boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output; every count happens on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Capture strobe for m_val/a_val, sampled on the rising edge |
| m_val | input | 10 | Requested main count M |
| a_val | input | 7 | Requested swallow count A |
| mc | output | 1 | Modulus control: 0 selects P+1, 1 selects P |
| fv_edge | output | 1 | One-clock pulse on the final count of each cycle |
| cfg_err | output | 1 | Last captured pair was illegal |

## Verification
The properties assume that the working M is never below 8. This means two fv_edge pulses can never fall on adjacent clocks, and a falling mc can only follow a cycle end. They also assume that the load inputs settle well before the rising edge. The stimulus drives load, m_val and a_val only on the falling edge. Illegal pairs are offered on purpose, but the bench expects them to stay out of the counting path, so only legal pairs ever reach the working registers. Loads are placed both in mid-cycle and on the final count, so that both the deferred-transfer rule and the coincident-edge rule are exercised.

// File: rtl/swallow_pkg.sv
package swallow_pkg;

  // A pair may run only if the main count reaches the floor and exceeds A.
  function automatic logic cfg_legal(input int unsigned m, input int unsigned a,
                                     input int unsigned m_floor);
    return (m >= m_floor) && (m > a);
  endfunction

  // Modulus control is high once the swallow phase has been used up.
  function automatic logic mc_level(input int unsigned pos, input int unsigned a);
    return pos >= a;
  endfunction

  // Final position of a cycle of length m.
  function automatic logic last_pos(input int unsigned pos, input int unsigned m);
    return pos == (m - 1);
  endfunction

endpackage

// File: rtl/sw_cfg_shadow.sv
module sw_cfg_shadow
  import swallow_pkg::*;
#(
  parameter int unsigned MW    = 10,
  parameter int unsigned AW    = 7,
  parameter int unsigned M_MIN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [MW-1:0] m_in,
  input  logic [AW-1:0] a_in,
  input  logic          boundary,
  output logic          pend_valid,
  output logic [MW-1:0] pend_m,
  output logic [AW-1:0] pend_a,
  output logic          cfg_err
);

  logic in_legal;
  assign in_legal = cfg_legal(32'(m_in), 32'(a_in), M_MIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid <= 1'b0;
      pend_m     <= '0;
      pend_a     <= '0;
      cfg_err    <= 1'b0;
    end else begin
      if (load) begin
        cfg_err <= !in_legal;
      end
      if (load && in_legal) begin
        pend_m     <= m_in;
        pend_a     <= a_in;
        pend_valid <= 1'b1;
      end else if (boundary) begin
        pend_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sw_active_cfg.sv
module sw_active_cfg #(
  parameter int unsigned MW    = 10,
  parameter int unsigned AW    = 7,
  parameter int unsigned DEF_M = 16,
  parameter int unsigned DEF_A = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          boundary,
  input  logic          pend_valid,
  input  logic [MW-1:0] pend_m,
  input  logic [AW-1:0] pend_a,
  output logic [MW-1:0] m_cur,
  output logic [AW-1:0] a_cur
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cur <= MW'(DEF_M);
      a_cur <= AW'(DEF_A);
    end else if (boundary && pend_valid) begin
      m_cur <= pend_m;
      a_cur <= pend_a;
    end
  end

endmodule

// File: rtl/sw_count.sv
module sw_count
  import swallow_pkg::*;
#(
  parameter int unsigned MW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [MW-1:0] m_cur,
  output logic [MW-1:0] pos,
  output logic          boundary
);

  assign boundary = last_pos(32'(pos), 32'(m_cur));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos <= '0;
    end else if (boundary) begin
      pos <= '0;
    end else begin
      pos <= pos + 1'b1;
    end
  end

endmodule

// File: rtl/sw_mc_gen.sv
module sw_mc_gen
  import swallow_pkg::*;
#(
  parameter int unsigned MW = 10,
  parameter int unsigned AW = 7
) (
  input  logic [MW-1:0] pos,
  input  logic [AW-1:0] a_cur,
  output logic          mc
);

  assign mc = mc_level(32'(pos), 32'(a_cur));

endmodule

// File: rtl/swallow_div.sv
module swallow_div #(
  parameter int unsigned MW    = 10,
  parameter int unsigned AW    = 7,
  parameter int unsigned M_MIN = 8,
  parameter int unsigned DEF_M = 16,
  parameter int unsigned DEF_A = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [MW-1:0] m_val,
  input  logic [AW-1:0] a_val,
  output logic          mc,
  output logic          fv_edge,
  output logic          cfg_err
);

  // Named internal events, also watched by the bound checker.
  logic          boundary;
  logic          pend_valid;
  logic [MW-1:0] pend_m;
  logic [AW-1:0] pend_a;
  logic [MW-1:0] m_cur;
  logic [AW-1:0] a_cur;
  logic [MW-1:0] pos;

  sw_cfg_shadow #(.MW(MW), .AW(AW), .M_MIN(M_MIN)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .m_in       (m_val),
    .a_in       (a_val),
    .boundary   (boundary),
    .pend_valid (pend_valid),
    .pend_m     (pend_m),
    .pend_a     (pend_a),
    .cfg_err    (cfg_err)
  );

  sw_active_cfg #(.MW(MW), .AW(AW), .DEF_M(DEF_M), .DEF_A(DEF_A)) u_active (
    .clk        (clk),
    .rst_n      (rst_n),
    .boundary   (boundary),
    .pend_valid (pend_valid),
    .pend_m     (pend_m),
    .pend_a     (pend_a),
    .m_cur      (m_cur),
    .a_cur      (a_cur)
  );

  sw_count #(.MW(MW)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .m_cur    (m_cur),
    .pos      (pos),
    .boundary (boundary)
  );

  sw_mc_gen #(.MW(MW), .AW(AW)) u_mc (
    .pos   (pos),
    .a_cur (a_cur),
    .mc    (mc)
  );

  assign fv_edge = boundary;

endmodule

// File: rtl/swallow_div_chk.sv
module swallow_div_chk #(
  parameter int unsigned MW = 10,
  parameter int unsigned AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load,
  input logic          mc,
  input logic          fv_edge,
  input logic          cfg_err,
  input logic [MW-1:0] m_cur,
  input logic [AW-1:0] a_cur
);

  // R2
  fv_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fv_edge |=> !fv_edge);

  // R3
  mc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mc) |-> $past(fv_edge));

  // R4
  mc_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fv_edge |=> (mc == (a_cur == '0)));

  // R5
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fv_edge) |-> ($stable(m_cur) && $stable(a_cur)));

  // R7
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(load));

  // R8
  err_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_err) |-> $past(load));

endmodule

bind swallow_div swallow_div_chk #(.MW(MW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load    (load),
  .mc      (mc),
  .fv_edge (fv_edge),
  .cfg_err (cfg_err),
  .m_cur   (m_cur),
  .a_cur   (a_cur)
);

// File: tb/swallow_div_bench.sv
`timescale 1ns/1ps
module swallow_div_bench;

  typedef struct {
    int    m;
    int    a;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [9:0] m_val = '0;
  logic [6:0] a_val = '0;
  logic       mc;
  logic       fv_edge;
  logic       cfg_err;

  int   n_checks = 0;
  int   n_fail = 0;
  exp_t exp_q[$];

  // bench model of the working and waiting pairs
  int    cur_m = 16, cur_a = 4;
  string cur_tag = "R1";
  bit    pv = 1'b0;
  int    pm, pa;
  string ptag;
  bit    saw_fv;

  always #2.5 clk = ~clk;

  swallow_div #(.MW(10), .AW(7), .M_MIN(8), .DEF_M(16), .DEF_A(4)) u_swallow_div (
    .clk(clk), .rst_n(rst_n), .load(load), .m_val(m_val), .a_val(a_val),
    .mc(mc), .fv_edge(fv_edge), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // one falling edge; at a cycle end, queue the expectation for the next cycle
  task automatic tick();
    exp_t e;
    @(negedge clk);
    saw_fv = fv_edge;
    if (fv_edge) begin
      if (pv) begin
        cur_m = pm; cur_a = pa; cur_tag = ptag; pv = 1'b0;
      end
      e.m = cur_m; e.a = cur_a; e.tag = cur_tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic run_cycles(input int n);
    int seen = 0;
    while (seen < n) begin
      tick();
      if (saw_fv) seen++;
    end
  endtask

  task automatic do_load(input int m, input int a, input string tag, input string err_tag);
    bit err_exp;
    load = 1'b1;
    m_val = 10'(m);
    a_val = 7'(a);
    if (m >= 8 && m > a) begin
      pv = 1'b1; pm = m; pa = a; ptag = tag; err_exp = 1'b0;
    end else begin
      err_exp = 1'b1;
    end
    tick();
    load = 1'b0;
    check(cfg_err == err_exp, err_tag, "cfg_err after load", int'(cfg_err), int'(err_exp));
  endtask

  // monitor: measure each cycle and compare with the queued expectation
  initial begin
    int   total = 0, lows = 0;
    bit   seen_hi = 1'b0, order_bad = 1'b0;
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        total++;
        if (!mc) begin
          lows++;
          if (seen_hi) order_bad = 1'b1;
        end else begin
          seen_hi = 1'b1;
        end
        if (fv_edge) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2", "unexpected cycle end, queue empty", total, 0);
          end else begin
            e = exp_q.pop_front();
            check(total == e.m, e.tag, "R2 cycle length", total, e.m);
            check(lows == e.a && !order_bad, e.tag, "R3 low count (order)", lows, e.a);
          end
          total = 0; lows = 0; seen_hi = 1'b0; order_bad = 1'b0;
        end
      end
    end
  end

  // watchdog
  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    exp_t e0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(mc == 1'b0, "R1", "mc in reset", int'(mc), 0);
    check(fv_edge == 1'b0, "R1", "fv_edge in reset", int'(fv_edge), 0);
    check(cfg_err == 1'b0, "R1", "cfg_err in reset", int'(cfg_err), 0);
    e0.m = 16; e0.a = 4; e0.tag = "R1";
    exp_q.push_back(e0);
    @(posedge clk);
    #1 rst_n = 1'b1;

    run_cycles(2);

    // R4 swallow count zero, loaded mid-cycle (R5)
    tick(); tick();
    do_load(20, 0, "R4", "R8");
    run_cycles(3);

    // R5 mid-cycle load of a new pair
    tick(); tick(); tick();
    do_load(40, 13, "R5", "R8");
    run_cycles(2);

    // R9 small extremes
    tick(); tick();
    do_load(9, 8, "R9", "R8");
    run_cycles(2);
    tick();
    do_load(8, 7, "R9", "R8");
    run_cycles(2);

    // R7 illegal pairs are refused
    tick();
    do_load(7, 0, "R7", "R7");
    run_cycles(2);
    tick();
    do_load(10, 10, "R7", "R7");
    run_cycles(2);

    // R8 legal load clears the flag; R9 large extreme
    tick(); tick();
    do_load(1023, 127, "R9", "R8");
    run_cycles(2);

    // R6 load on the final count of a cycle
    run_cycles(1);
    do_load(12, 3, "R6", "R8");
    run_cycles(3);

    // R10 two loads in one cycle, the last one wins
    tick(); tick();
    do_load(30, 5, "R10", "R8");
    do_load(25, 10, "R10", "R8");
    run_cycles(3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule